// File: doc/BRIEF.md
# DMA Transfer Byte Counter with End-of-Transfer Interrupt

This block sits beside the data path of a host controller's buffer memory. Software programs a 16-bit byte count and a DMA configuration word through a small command/data port. The configuration word chooses the buffer type, the transfer direction and whether DMA runs. Setting the start bit of the configuration word arms the counter with the programmed count. From then on, each byte strobe from the data path lowers the remaining count by one.

When the last byte is counted, the block raises an end-of-transfer event. The event sets a sticky bit in the interrupt status register and marks the completed buffer type in a buffer status register. Both registers are cleared by writing ones. The interrupt output is asserted when a status bit is set, its enable bit is set and the global interrupt enable is on.

Commands are 8-bit codes. Bit 7 of a code selects a write when 1 and a read when 0, and bits 6:0 select the register. Read data is returned one cycle after the command, together with a valid flag.

Top module: `dma_xfer_ctl`

## Requirements
- R1: After reset, the count, remaining-count, configuration, enable, global-enable, status and buffer status registers all read 0. The `irq`, `eot_pulse` and `dma_on` outputs are 0.
- R2: The transfer count register is read with code 22h and written with code A2h. Any code with bit 7 clear returns the addressed register on `rd_data` one cycle later, with `rd_valid` high for that one cycle.
- R3: The configuration register is written with A1h and read with 21h. Its fields are: bit 4 DMA enable (`dma_on`), bits 3:1 buffer type (`buf_sel`), and bit 0 direction (`dir_wr`, 1 = write into the buffer). The start bit, bit 7, always reads back as 0.
- R4: A loaded count takes effect only when a configuration write sets bit 7. Before that, the remaining count (read at code 23h) stays unchanged. Byte strobes lower the remaining count only while the counter is armed and configuration bit 4 is 1.
- R5: When an armed count goes from 1 to 0, `eot_pulse` is high for exactly the one cycle after that strobe is taken. Bit 2 of the interrupt status register (read 24h, write A4h) becomes 1 at the same time.
- R6: After completion, further byte strobes leave the remaining count at 0 and raise no event until the counter is armed again.
- R7: Arming with a loaded count of 0 gives `eot_pulse` on the cycle after the arming write, and sets status bit 2.
- R8: A write to A4h clears each status bit whose data bit is 1 and leaves every bit whose data bit is 0. Writing FFh clears all bits.
- R9: If a clear of status bit 2 and a new end-of-transfer event occur in the same cycle, the bit ends up set.
- R10: `irq` is a registered level. It is 1 one cycle after some status bit is set with its enable bit (written with A5h) set while bit 0 of the global configuration register (written with A0h) is 1, and it is 0 one cycle after no such bit remains.
- R11: Each completion sets one bit of the buffer status register (read 2Ch, write-one-to-clear with ACh), chosen by the buffer type that was armed: type 000 sets bit 0, 001 bit 1, 010 bit 2, 011 bit 3, and any type 1xx sets bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 8 | Command code; bit 7 = write |
| wr_data | input | 16 | Write data for write commands |
| byte_stb | input | 1 | One byte moved by the data path |
| rd_data | output | 16 | Read result, registered |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| dma_on | output | 1 | Configuration DMA enable bit |
| buf_sel | output | 3 | Configuration buffer type |
| dir_wr | output | 1 | Configuration direction bit |
| eot_pulse | output | 1 | One-cycle end-of-transfer pulse |
| irq | output | 1 | Interrupt request level |

## Verification
Every result has a fixed latency:
- Read data, `eot_pulse`, the status bits and the buffer status bits change at the first clock edge after the command or strobe that causes them.
- A zero-count start reaches `eot_pulse` one edge later than a counted completion.
- `irq` trails the status and enable state by one further edge.

The bench drives inputs on falling edges and samples outputs on the next falling edge, or on the one after for `irq` and the zero-count start. A monitor pops each queued read expectation on the falling edge where `rd_valid` is high, so a read that returns too early or too late pairs with the wrong value.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam logic [6:0] SEL_GLOBAL = 7'h20;
  localparam logic [6:0] SEL_CFG    = 7'h21;
  localparam logic [6:0] SEL_COUNT  = 7'h22;
  localparam logic [6:0] SEL_REMAIN = 7'h23;
  localparam logic [6:0] SEL_STAT   = 7'h24;
  localparam logic [6:0] SEL_IEN    = 7'h25;
  localparam logic [6:0] SEL_BSTAT  = 7'h2C;

  localparam int EOT_BIT  = 2;
  localparam int BUF_KIND = 5;

  typedef struct packed {
    logic       start;
    logic [1:0] spare;
    logic       dma_en;
    logic [2:0] buf_type;
    logic       dir_wr;
  } cfg_t;

  function automatic logic [BUF_KIND-1:0] buf_onehot(input logic [2:0] t);
    logic [BUF_KIND-1:0] v;
    v = '0;
    if (t[2]) v[4] = 1'b1;
    else      v[t[1:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] count_down(input logic [15:0] c);
    return (c == 16'd0) ? 16'd0 : c - 16'd1;
  endfunction

  function automatic logic irq_level(input logic [7:0] stat, input logic [7:0] en,
                                     input logic gen);
    return gen & (|(stat & en));
  endfunction
endpackage

// File: rtl/dxc_regs.sv
module dxc_regs
  import dxc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_code,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [STAT_W-1:0]   stat,
  input  logic [BUF_KIND-1:0] bstat,
  input  logic [CNT_W-1:0]    remain,
  output cfg_t                cfg,
  output logic [CNT_W-1:0]    xcount,
  output logic [STAT_W-1:0]   ien,
  output logic                gen,
  output logic                arm,
  output logic [2:0]          arm_type,
  output logic [STAT_W-1:0]   stat_clr,
  output logic [BUF_KIND-1:0] bstat_clr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid
);
  logic       is_wr, is_rd;
  logic [6:0] sel;
  logic [DATA_W-1:0] rd_mux;

  assign is_wr = cmd_valid & cmd_code[7];
  assign is_rd = cmd_valid & ~cmd_code[7];
  assign sel   = cmd_code[6:0];

  assign arm       = is_wr && (sel == SEL_CFG) && wr_data[7];
  assign arm_type  = wr_data[3:1];
  assign stat_clr  = (is_wr && sel == SEL_STAT)  ? wr_data[STAT_W-1:0]   : '0;
  assign bstat_clr = (is_wr && sel == SEL_BSTAT) ? wr_data[BUF_KIND-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      xcount <= '0;
      ien    <= '0;
      gen    <= 1'b0;
    end else if (is_wr) begin
      case (sel)
        SEL_CFG: begin
          cfg       <= cfg_t'(wr_data[7:0]);
          cfg.start <= 1'b0;
          cfg.spare <= 2'b00;
        end
        SEL_COUNT:  xcount <= wr_data[CNT_W-1:0];
        SEL_IEN:    ien    <= wr_data[STAT_W-1:0];
        SEL_GLOBAL: gen    <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CFG:    rd_mux = DATA_W'(cfg);
      SEL_COUNT:  rd_mux = DATA_W'(xcount);
      SEL_REMAIN: rd_mux = DATA_W'(remain);
      SEL_STAT:   rd_mux = DATA_W'(stat);
      SEL_IEN:    rd_mux = DATA_W'(ien);
      SEL_GLOBAL: rd_mux = DATA_W'(gen);
      SEL_BSTAT:  rd_mux = DATA_W'(bstat);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/dxc_counter.sv
module dxc_counter
  import dxc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [2:0]       arm_type,
  input  logic [CNT_W-1:0] xcount,
  input  logic             dma_en,
  input  logic             byte_stb,
  output logic [CNT_W-1:0] remain,
  output logic             active,
  output logic [2:0]       done_type,
  output logic             eot_evt,
  output logic             eot_pulse
);
  logic zero_pend;
  logic cnt_en;
  logic last_byte;

  assign cnt_en    = active & dma_en & byte_stb & ~arm;
  assign last_byte = cnt_en & (remain == CNT_W'(1));
  assign eot_evt   = zero_pend | last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      active    <= 1'b0;
      zero_pend <= 1'b0;
      eot_pulse <= 1'b0;
      done_type <= '0;
    end else begin
      eot_pulse <= eot_evt;
      zero_pend <= 1'b0;
      if (arm) begin
        remain    <= xcount;
        done_type <= arm_type;
        active    <= (xcount != '0);
        zero_pend <= (xcount == '0);
      end else if (cnt_en) begin
        remain <= CNT_W'(count_down(16'(remain)));
        if (last_byte) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dxc_irq.sv
module dxc_irq
  import dxc_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eot_evt,
  input  logic [2:0]          done_type,
  input  logic [STAT_W-1:0]   stat_clr,
  input  logic [BUF_KIND-1:0] bstat_clr,
  input  logic [STAT_W-1:0]   ien,
  input  logic                gen,
  output logic [STAT_W-1:0]   stat,
  output logic [BUF_KIND-1:0] bstat,
  output logic                irq
);
  logic [STAT_W-1:0]   stat_set;
  logic [BUF_KIND-1:0] bstat_set;

  assign stat_set  = eot_evt ? (STAT_W'(1) << EOT_BIT) : '0;
  assign bstat_set = eot_evt ? buf_onehot(done_type) : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stat[i] <= 1'b0;
      else if (stat_set[i]) stat[i] <= 1'b1;
      else if (stat_clr[i]) stat[i] <= 1'b0;
    end
  end

  for (genvar j = 0; j < BUF_KIND; j++) begin : g_bstat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            bstat[j] <= 1'b0;
      else if (bstat_set[j]) bstat[j] <= 1'b1;
      else if (bstat_clr[j]) bstat[j] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_level(8'(stat), 8'(ien), gen);
  end
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dxc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              byte_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              dma_on,
  output logic [2:0]        buf_sel,
  output logic              dir_wr,
  output logic              eot_pulse,
  output logic              irq
);
  cfg_t                cfg;
  logic [CNT_W-1:0]    xcount;
  logic [CNT_W-1:0]    remain;
  logic [STAT_W-1:0]   ien;
  logic [STAT_W-1:0]   stat;
  logic [STAT_W-1:0]   stat_clr;
  logic [BUF_KIND-1:0] bstat;
  logic [BUF_KIND-1:0] bstat_clr;
  logic                gen;
  logic                arm;
  logic [2:0]          arm_type;
  logic [2:0]          done_type;
  logic                active;
  logic                eot_evt;

  dxc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STAT_W(STAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_data(wr_data), .stat(stat), .bstat(bstat), .remain(remain),
    .cfg(cfg), .xcount(xcount), .ien(ien), .gen(gen), .arm(arm),
    .arm_type(arm_type), .stat_clr(stat_clr), .bstat_clr(bstat_clr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  dxc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .arm_type(arm_type), .xcount(xcount),
    .dma_en(cfg.dma_en), .byte_stb(byte_stb), .remain(remain), .active(active),
    .done_type(done_type), .eot_evt(eot_evt), .eot_pulse(eot_pulse)
  );

  dxc_irq #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .eot_evt(eot_evt), .done_type(done_type),
    .stat_clr(stat_clr), .bstat_clr(bstat_clr), .ien(ien), .gen(gen),
    .stat(stat), .bstat(bstat), .irq(irq)
  );

  assign dma_on  = cfg.dma_en;
  assign buf_sel = cfg.buf_type;
  assign dir_wr  = cfg.dir_wr;
endmodule

// File: rtl/dxc_chk.sv
module dxc_chk #(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              active,
  input logic              dma_en,
  input logic              byte_stb,
  input logic [CNT_W-1:0]  remain,
  input logic              eot_evt,
  input logic              eot_pulse,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] stat_clr,
  input logic [STAT_W-1:0] ien,
  input logic              gen,
  input logic              irq
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !arm) |=> $stable(remain)); // R4

  AST_ONE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dma_en && byte_stb && !arm) |=> (remain == $past(remain) - CNT_W'(1))); // R4

  AST_EOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    eot_evt |=> eot_pulse); // R5

  AST_EOT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    eot_evt |=> stat[2]); // R9

  AST_STAT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[2]) |-> $past(stat_clr[2])); // R8

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && |(stat & ien)) |=> irq); // R10

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen && |(stat & ien)) |=> !irq); // R10
endmodule

bind dma_xfer_ctl dxc_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .active(active), .dma_en(cfg.dma_en),
  .byte_stb(byte_stb), .remain(remain), .eot_evt(eot_evt), .eot_pulse(eot_pulse),
  .stat(stat), .stat_clr(stat_clr), .ien(ien), .gen(gen), .irq(irq)
);

// File: tb/tb_dma_xfer_ctl.sv
module tb_dma_xfer_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [15:0] wr_data = 16'h0000;
  logic        byte_stb = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        dma_on, dir_wr, eot_pulse, irq;
  logic [2:0]  buf_sel;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dma_xfer_ctl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_data(wr_data), .byte_stb(byte_stb), .rd_data(rd_data), .rd_valid(rd_valid),
    .dma_on(dma_on), .buf_sel(buf_sel), .dir_wr(dir_wr), .eot_pulse(eot_pulse),
    .irq(irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] c, input logic [15:0] d);
    cmd_valid = 1'b1; cmd_code = c; wr_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] c, input logic [15:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic stb(input int n);
    for (int i = 0; i < n; i++) begin
      byte_stb = 1'b1;
      @(negedge clk);
    end
    byte_stb = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2: unexpected read data %0h, expected none", rd_data);
      end else begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(16'(irq), 16'd0, "R1 irq");
    chk(16'(eot_pulse), 16'd0, "R1 eot");
    chk(16'(dma_on), 16'd0, "R1 dma_on");
    rd(8'h22, 16'h0000, "R1 count");
    rd(8'h24, 16'h0000, "R1 status");
    rd(8'h2C, 16'h0000, "R1 bstatus");
    // R2 count register
    wr(8'hA2, 16'h0005);
    rd(8'h22, 16'h0005, "R2 count readback");
    // R3 config fields: enable, type ATL 011, dir write
    wr(8'hA1, 16'h0017);
    chk(16'(dma_on), 16'd1, "R3 dma_on");
    chk(16'(buf_sel), 16'd3, "R3 buf_sel");
    chk(16'(dir_wr), 16'd1, "R3 dir_wr");
    // R4 count not in effect without start
    stb(3);
    rd(8'h23, 16'h0000, "R4 remain before start");
    wr(8'hA1, 16'h0097);
    rd(8'h21, 16'h0017, "R3 start bit reads 0");
    rd(8'h23, 16'h0005, "R4 remain after start");
    // R5 countdown to completion
    stb(4);
    chk(16'(eot_pulse), 16'd0, "R5 no early eot");
    rd(8'h23, 16'h0001, "R4 remain after 4");
    stb(1);
    chk(16'(eot_pulse), 16'd1, "R5 eot pulse");
    @(negedge clk);
    chk(16'(eot_pulse), 16'd0, "R5 eot one cycle");
    // R6 strobes after completion ignored
    stb(3);
    chk(16'(eot_pulse), 16'd0, "R6 no eot after done");
    rd(8'h23, 16'h0000, "R6 remain stays 0");
    rd(8'h24, 16'h0004, "R5 status bit 2");
    // R10 gating
    chk(16'(irq), 16'd0, "R10 irq no enable");
    wr(8'hA5, 16'h0004);
    @(negedge clk);
    chk(16'(irq), 16'd0, "R10 irq no global");
    wr(8'hA0, 16'h0001);
    @(negedge clk);
    chk(16'(irq), 16'd1, "R10 irq asserted");
    // R11 ATL completion
    rd(8'h2C, 16'h0008, "R11 ATL bit");
    // R4 counting disabled by enable bit 0
    wr(8'hA1, 16'h0086);
    stb(2);
    rd(8'h23, 16'h0005, "R4 no count when disabled");
    // R8 write-one-to-clear
    wr(8'hA4, 16'h0001);
    rd(8'h24, 16'h0004, "R8 zero bits kept");
    chk(16'(irq), 16'd1, "R10 irq held");
    wr(8'hA4, 16'h00FF);
    rd(8'h24, 16'h0000, "R8 clear all");
    chk(16'(irq), 16'd0, "R10 irq dropped");
    wr(8'hAC, 16'h0008);
    rd(8'h2C, 16'h0000, "R11 bstatus clear");
    // R7 zero-count start, direct type 1xx
    wr(8'hA2, 16'h0000);
    wr(8'hA1, 16'h0099);
    chk(16'(eot_pulse), 16'd0, "R7 not same cycle");
    @(negedge clk);
    chk(16'(eot_pulse), 16'd1, "R7 zero-count eot");
    chk(16'(buf_sel), 16'd4, "R3 direct type");
    rd(8'h2C, 16'h0010, "R11 direct bit");
    rd(8'h24, 16'h0004, "R7 status set");
    // R9 clear and event in same cycle
    wr(8'hA1, 16'h0099);
    wr(8'hA4, 16'h0004);
    rd(8'h24, 16'h0004, "R9 set wins");
    wr(8'hA4, 16'h0004);
    rd(8'h24, 16'h0000, "R8 single bit clear");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule